// File: doc/BRIEF.md
# Multichannel Sample Serializer

This block turns one parallel sample per channel into a serial bit stream per channel, together with a frame clock and a bit clock that travel beside the data. Each sample period is split into twelve bit slots. Two zero pad slots lead the frame and the ten sample bits follow them. The bit rate is twelve times the sample rate. The whole block runs from one fast clock. A one-cycle strobe `bit_en` marks each bit slot, and the fast clock stands in for the twelve-times bit-rate clock.

A mode field can replace the converter data on every channel with a test stream: alternating ones and zeros for deskew, a half-low/half-high word for frame alignment, or a user-supplied ten-bit word. The transmit order is least significant bit first by default and can be switched to most significant bit first. Switching the order also reverses the fixed test streams. Any channel can be powered down, and it then drives a constant zero.

All configuration and sample inputs are sampled only at the first slot of a frame. A frame is never split between two settings.

Top module: `mcs_serializer`

## Requirements
- R1: While `rst` is high, and after it until the first `bit_en`, `ser_out`, `frame_clk` and `bit_clk` are all 0. The first `bit_en` after reset starts slot 0 of a frame.
- R2: Every output changes only in the cycle after a `bit_en` strobe and holds its value otherwise. Each strobe advances one slot, and a frame spans exactly 12 strobes (slots 0 to 11).
- R3: In mode 2'b00 with `msb_first`=0, slots 0 and 1 of each channel are 0, and slot 2+i carries bit i of that channel's sample (sample c is `sample_bus[c*10 +: 10]`).
- R4: With `msb_first`=1 in mode 2'b00, slots 0 and 1 are 0, and slot 2+i carries sample bit 9-i.
- R5: `frame_clk` is 1 during slots 0 to 5 and 0 during slots 6 to 11, so it rises at the start of slot 0.
- R6: `bit_clk` is 1 on even slots and 0 on odd slots, so it changes on every slot.
- R7: Mode 2'b01 (deskew) sends 1 on even slots and 0 on odd slots when `msb_first`=0. With `msb_first`=1 it sends 1 on odd slots and 0 on even slots.
- R8: Mode 2'b10 (sync) sends 0 on slots 0 to 5 and 1 on slots 6 to 11 when `msb_first`=0. With `msb_first`=1 it sends 1 on slots 0 to 5 and 0 on slots 6 to 11.
- R9: Mode 2'b11 sends `custom_word` in place of the sample on every channel, with the same pad slots and bit order as R3 and R4.
- R10: A channel whose `chan_pd` bit (bit c for channel c) is 1 at the start of a frame drives 0 on all 12 slots of that frame.
- R11: Changes to `mode_sel`, `msb_first`, `custom_word`, `chan_pd` or `sample_bus` during slots 1 to 11 have no effect until the next slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe marking each bit slot |
| sample_bus | input | NCH*DW (80) | Parallel samples, channel c at bits c*DW +: DW |
| mode_sel | input | 2 | 00 data, 01 deskew, 10 sync, 11 custom word |
| msb_first | input | 1 | 0 sends least significant bit first, 1 reverses the order |
| custom_word | input | DW (10) | User test word for mode 11 |
| chan_pd | input | NCH (8) | Per-channel power-down |
| ser_out | output | NCH (8) | Serial data, one line per channel |
| frame_clk | output | 1 | Frame clock, high for the first half of the frame |
| bit_clk | output | 1 | Bit clock, changing on every slot |

## Verification
The bench builds the block with its default parameters: eight channels, ten data bits and two pad slots. These values give the twelve-slot frame, its six-slot frame-clock halves and the distinct reversal of the sync and deskew streams. With eight channels, per-channel sample values and an asymmetric power-down mask show up in lane routing and lane swaps. The strobe is driven every cycle, every third cycle and at random. These patterns exercise the hold-between-strobes behaviour and the sampling of configuration at the frame boundary, including changes made in the middle of a frame.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [1:0] {
    MODE_DATA   = 2'd0,
    MODE_DESKEW = 2'd1,
    MODE_SYNC   = 2'd2,
    MODE_CUSTOM = 2'd3
  } out_mode_e;

  // bit k set for every even slot k < n
  function automatic logic [63:0] even_slots(input int n);
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < 64; k++) begin
      if (k < n) r[k] = (k % 2 == 0);
    end
    return r;
  endfunction

  // bit k set for the second half of n slots
  function automatic logic [63:0] upper_half(input int n);
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < 64; k++) begin
      if (k < n) r[k] = (k >= n / 2);
    end
    return r;
  endfunction

  // bit k set for the first half of n slots
  function automatic logic [63:0] lower_half(input int n);
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < 64; k++) begin
      if (k < n) r[k] = (k < n / 2);
    end
    return r;
  endfunction

endpackage

// File: rtl/mcs_slot_timer.sv
module mcs_slot_timer #(
  parameter int SLOTS = 12,
  parameter int SW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  output logic [SW-1:0] slot,
  output logic          frame_go
);

  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (bit_en) begin
      slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end
  end

  assign slot     = slot_q;
  assign frame_go = bit_en && (slot_q == '0);

  // R2: slot index stays inside the frame
  p_slot_range_r2: assert property (@(posedge clk) disable iff (rst)
    slot_q <= LAST);

  // R2: no strobe, no advance
  p_slot_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(slot_q));

endmodule

// File: rtl/mcs_word_former.sv
module mcs_word_former
  import mcs_pkg::*;
#(
  parameter int DW    = 10,
  parameter int PAD   = 2,
  parameter int SLOTS = DW + PAD
) (
  input  logic [1:0]       mode,
  input  logic             msb_first,
  input  logic [DW-1:0]    sample,
  input  logic [DW-1:0]    custom,
  input  logic             pd,
  output logic [SLOTS-1:0] word
);

  localparam logic [SLOTS-1:0] DESKEW_W = even_slots(SLOTS)[SLOTS-1:0];
  localparam logic [SLOTS-1:0] SYNC_W   = upper_half(SLOTS)[SLOTS-1:0];

  out_mode_e        mode_e;
  logic [DW-1:0]    payload;
  logic [SLOTS-1:0] data_w;
  logic [SLOTS-1:0] pat_w;

  assign mode_e = out_mode_e'(mode);

  always_comb begin
    payload = (mode_e == MODE_CUSTOM) ? custom : sample;
    data_w  = '0;
    for (int i = 0; i < DW; i++) begin
      data_w[PAD + i] = msb_first ? payload[DW-1-i] : payload[i];
    end
    pat_w = (mode_e == MODE_DESKEW) ? DESKEW_W : SYNC_W;
    word  = '0;
    if (!pd) begin
      if (mode_e == MODE_DATA || mode_e == MODE_CUSTOM) begin
        word = data_w;
      end else begin
        for (int k = 0; k < SLOTS; k++) begin
          word[k] = msb_first ? pat_w[SLOTS-1-k] : pat_w[k];
        end
      end
    end
  end

endmodule

// File: rtl/mcs_lane.sv
module mcs_lane #(
  parameter int SLOTS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             load,
  input  logic [SLOTS-1:0] word,
  output logic             ser
);

  logic [SLOTS-2:0] rest_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ser    <= 1'b0;
      rest_q <= '0;
    end else if (load) begin
      ser    <= word[0];
      rest_q <= word[SLOTS-1:1];
    end else if (bit_en) begin
      ser    <= rest_q[0];
      rest_q <= {1'b0, rest_q[SLOTS-2:1]};
    end
  end

  // R2: a lane only moves on a slot strobe
  p_lane_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(ser));

endmodule

// File: rtl/mcs_serializer.sv
module mcs_serializer
  import mcs_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 10,
  parameter int PAD = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [NCH*DW-1:0] sample_bus,
  input  logic [1:0]        mode_sel,
  input  logic              msb_first,
  input  logic [DW-1:0]     custom_word,
  input  logic [NCH-1:0]    chan_pd,
  output logic [NCH-1:0]    ser_out,
  output logic              frame_clk,
  output logic              bit_clk
);

  localparam int SLOTS = DW + PAD;
  localparam int SW    = $clog2(SLOTS);
  localparam logic [SLOTS-1:0] FCLK_W = lower_half(SLOTS)[SLOTS-1:0];
  localparam logic [SLOTS-1:0] BCLK_W = even_slots(SLOTS)[SLOTS-1:0];

  logic [SW-1:0] slot_q;
  logic          frame_go;

  mcs_slot_timer #(.SLOTS(SLOTS), .SW(SW)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .slot     (slot_q),
    .frame_go (frame_go)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_chan
      logic [SLOTS-1:0] word;

      mcs_word_former #(.DW(DW), .PAD(PAD), .SLOTS(SLOTS)) form_i (
        .mode      (mode_sel),
        .msb_first (msb_first),
        .sample    (sample_bus[c*DW +: DW]),
        .custom    (custom_word),
        .pd        (chan_pd[c]),
        .word      (word)
      );

      mcs_lane #(.SLOTS(SLOTS)) lane_i (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .load   (frame_go),
        .word   (word),
        .ser    (ser_out[c])
      );

      // R3: word-carrying modes start each frame with a pad zero
      p_pad_zero_r3: assert property (@(posedge clk) disable iff (rst)
        frame_go && (mode_sel == MODE_DATA || mode_sel == MODE_CUSTOM) |=> !ser_out[c]);

      // R10: a channel powered down at the frame start emits zero
      p_pd_zero_r10: assert property (@(posedge clk) disable iff (rst)
        frame_go && chan_pd[c] |=> !ser_out[c]);
    end
  endgenerate

  mcs_lane #(.SLOTS(SLOTS)) fclk_lane_i (
    .clk    (clk),
    .rst    (rst),
    .bit_en (bit_en),
    .load   (frame_go),
    .word   (FCLK_W),
    .ser    (frame_clk)
  );

  mcs_lane #(.SLOTS(SLOTS)) bclk_lane_i (
    .clk    (clk),
    .rst    (rst),
    .bit_en (bit_en),
    .load   (frame_go),
    .word   (BCLK_W),
    .ser    (bit_clk)
  );

  // R5: frame clock rises only as slot 0 is emitted
  p_frame_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_clk) |-> slot_q == SW'(1));

  // R5: frame clock low from the middle slot on
  p_frame_low_r5: assert property (@(posedge clk) disable iff (rst)
    bit_en && slot_q == SW'(SLOTS / 2) |=> !frame_clk);

  // R6: bit clock changes on every slot
  p_bitclk_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> bit_clk != $past(bit_clk));

endmodule

// File: tb/mcs_serializer_tb.sv
module mcs_serializer_tb_top;

  localparam int NCH = 8;
  localparam int DW  = 10;
  localparam int NS  = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bit_en = 1'b0;
  logic [NCH*DW-1:0] sample_bus = '0;
  logic [1:0]        mode_sel = 2'd0;
  logic              msb_first = 1'b0;
  logic [DW-1:0]     custom_word = '0;
  logic [NCH-1:0]    chan_pd = '0;
  logic [NCH-1:0]    ser_out;
  logic              frame_clk;
  logic              bit_clk;

  always #5 clk = ~clk;

  mcs_serializer #(.NCH(NCH), .DW(DW), .PAD(2)) dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .sample_bus(sample_bus),
    .mode_sel(mode_sel), .msb_first(msb_first), .custom_word(custom_word),
    .chan_pd(chan_pd), .ser_out(ser_out), .frame_clk(frame_clk), .bit_clk(bit_clk)
  );

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R1";
  int    en_mode = 0;   // 0 off, 1 every cycle, 3 every third, -1 random
  bit    done = 0;

  // reference model state
  int             mslot = 0;
  int             f_mode;
  bit             f_msb;
  logic [NCH*DW-1:0] f_smp;
  logic [DW-1:0]  f_cus;
  logic [NCH-1:0] f_pd;
  logic [NCH-1:0] exp_ser = '0;
  logic           exp_fc = 1'b0;
  logic           exp_bc = 1'b0;

  function automatic logic model_bit(int ch, int k);
    logic [DW-1:0] v;
    if (f_pd[ch]) return 1'b0;
    case (f_mode)
      1: return f_msb ? (k % 2 == 1) : (k % 2 == 0);
      2: return f_msb ? (k < 6) : (k >= 6);
      default: begin
        v = (f_mode == 3) ? f_cus : f_smp[ch*DW +: DW];
        if (k < 2) return 1'b0;
        return f_msb ? v[DW-1-(k-2)] : v[k-2];
      end
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mslot = 0; exp_ser = '0; exp_fc = 1'b0; exp_bc = 1'b0;
    end else if (bit_en) begin
      if (mslot == 0) begin
        f_mode = int'(mode_sel); f_msb = msb_first; f_smp = sample_bus;
        f_cus = custom_word; f_pd = chan_pd;
      end
      for (int ch = 0; ch < NCH; ch++) exp_ser[ch] = model_bit(ch, mslot);
      exp_fc = (mslot < 6);
      exp_bc = (mslot % 2 == 0);
      mslot = (mslot + 1) % NS;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (ser_out !== exp_ser) begin
        fails++;
        $display("FAIL %s ser_out got %h expected %h", tag, ser_out, exp_ser);
      end
      checks++;
      if (frame_clk !== exp_fc) begin
        fails++;
        $display("FAIL R5 frame_clk got %b expected %b (%s)", frame_clk, exp_fc, tag);
      end
      checks++;
      if (bit_clk !== exp_bc) begin
        fails++;
        $display("FAIL R6 bit_clk got %b expected %b (%s)", bit_clk, exp_bc, tag);
      end
    end
  end

  // slot strobe generator
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (en_mode == 0) bit_en = 1'b0;
      else if (en_mode < 0) bit_en = ($urandom % 3 == 0);
      else begin
        cnt = (cnt + 1) % en_mode;
        bit_en = (cnt == 0);
      end
    end
  end

  task automatic new_samples();
    for (int ch = 0; ch < NCH; ch++) sample_bus[ch*DW +: DW] = DW'($urandom);
  endtask

  task automatic run(int cycles, bit churn);
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      if (n % 7 == 3) new_samples();
      if (churn && n % 5 == 2) begin
        mode_sel = 2'($urandom);
        msb_first = 1'($urandom);
        custom_word = DW'($urandom);
        chan_pd = NCH'($urandom);
      end
    end
  endtask

  initial begin
    tag = "R1";
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);        // R1: idle until first strobe
    tag = "R3"; mode_sel = 2'd0; msb_first = 1'b0; en_mode = 1;
    run(NS * 6, 0);
    tag = "R4"; msb_first = 1'b1;
    run(NS * 6, 0);
    tag = "R7"; mode_sel = 2'd1; msb_first = 1'b0; en_mode = 3;
    run(NS * 3 * 3, 0);
    msb_first = 1'b1;
    run(NS * 3 * 3, 0);
    tag = "R8"; mode_sel = 2'd2; msb_first = 1'b0;
    run(NS * 3 * 3, 0);
    msb_first = 1'b1;
    run(NS * 3 * 3, 0);
    tag = "R9"; mode_sel = 2'd3; custom_word = 10'h2d3; msb_first = 1'b0; en_mode = 1;
    run(NS * 4, 0);
    msb_first = 1'b1;
    run(NS * 4, 0);
    tag = "R10"; mode_sel = 2'd0; msb_first = 1'b0; chan_pd = 8'b1010_0101;
    run(NS * 4, 0);
    chan_pd = 8'b0000_0001;
    run(NS * 4, 0);
    chan_pd = '0;
    tag = "R11";
    run(NS * 20, 1);
    tag = "R2"; en_mode = -1;
    run(NS * 60, 1);
    en_mode = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired during %s", tag);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule